// File: doc/BRIEF.md
# Supply Start-Up and Fault Mute Sequencer

This block brings the gain path of a two-channel audio volume stage from power-on to normal operation. It holds the internal reset and forces the output hardware mute while a timed reset window, measured in milliseconds, runs. It then requests an automatic offset calibration. When calibration reports completion, or a bounded wait runs out, it loads both channel gain codes with the software-mute value 0x00 and hands control to the host.

The supply-good indication comes from an analog comparator. It is first synchronised and then debounced, so only a level that stays stable for a set number of cycles is acted on. Losing supply in any state sends the machine back to its reset state, and the whole start-up order runs again. The external mute pin forces the hardware mute while it is held. Its rising edge during normal operation also asks for a fresh offset calibration. Gain writes from the serial port take effect only once the sequence has finished.

Top module: `pwr_mute_seq`

## Requirements
- R1: While `rst_n` is low: `int_rst_o`=1, `hw_mute_o`=1, `cal_start_o`=0, `preset_o`=0, and both gain outputs are 0x00.
- R2: A change of `supply_good_i` is acted on only after its synchronised value differs from the filtered level for DEB_CYCLES consecutive cycles. A pulse lasting fewer cycles changes no output.
- R3: After `supply_good_i` rises and stays high, `int_rst_o` falls exactly RST_CYCLES+DEB_CYCLES+2 clock edges later, where RST_CYCLES = CLK_HZ/1000*RESET_MS.
- R4: `cal_start_o` is a one-cycle pulse. It is high in the first cycle after `int_rst_o` falls.
- R5: If `cal_done_i` is high at a clock edge during calibration, `preset_o` is high in the following cycle.
- R6: Without `cal_done_i`, `preset_o` rises CAL_LIMIT edges after `int_rst_o` falls. When `cal_done_i` arrives on the final timeout cycle, there is still a single one-cycle preset.
- R7: `preset_o` lasts one cycle. In the following cycle both gain outputs are 0x00.
- R8: A write (`wr_en_i`=1) loads `wr_left_i` and `wr_right_i` onto the gain outputs one edge later, but only in the run state. Writes during reset or during the preset cycle leave the gains unchanged.
- R9: Loss of supply in any state raises `int_rst_o` DEB_CYCLES+3 edges after the input falls and clears both gains. On recovery the full sequence of R3 to R7 runs again.
- R10: In the run state, raising `mute_pin_i` sets `hw_mute_o` 2 edges later and gives a `cal_start_o` pulse 3 edges later. Gains are untouched. Releasing the pin clears `hw_mute_o` 2 edges later.
- R11: `hw_mute_o` is 1 in every state except run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_good_i | input | 1 | Raw supply-above-threshold indication |
| cal_done_i | input | 1 | Offset calibration finished |
| mute_pin_i | input | 1 | External hardware mute request |
| wr_en_i | input | 1 | Gain write strobe from the serial port |
| wr_left_i | input | GW | Left gain code to write |
| wr_right_i | input | GW | Right gain code to write |
| int_rst_o | output | 1 | Internal reset to the rest of the device |
| hw_mute_o | output | 1 | Hardware mute force |
| cal_start_o | output | 1 | Offset calibration start pulse |
| preset_o | output | 1 | Gain preset command (both to 0x00) |
| gain_left_o | output | GW | Current left gain code |
| gain_right_o | output | GW | Current right gain code |

## Verification
Two events can land on the same edge. The first is a host gain write that arrives in the single preset cycle; the preset must win, so the gains read 0x00 afterwards and not the written data. The second is a calibration-done that arrives on the very edge where the timeout also expires; this must give exactly one preset cycle and not a repeated or lost one. The bench places the write strobe on the cycle where it sees `preset_o` high, and it times `cal_done_i` for the cycle CAL_LIMIT-1 edges after the reset ends. In both cases it judges the gain outputs and the preset width in the cycles that follow.

// File: rtl/pms_pkg.sv
package pms_pkg;
    typedef enum logic [1:0] {
        ST_RESET  = 2'd0,
        ST_CAL    = 2'd1,
        ST_PRESET = 2'd2,
        ST_RUN    = 2'd3
    } pms_state_e;
endpackage

// File: rtl/pms_supply_filter.sv
// Two-flop synchroniser followed by a consecutive-sample debounce.
module pms_supply_filter #(
    parameter int DEB_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic ok_o
);
    localparam int CW = (DEB_CYCLES > 1) ? $clog2(DEB_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(DEB_CYCLES - 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          filt;
        logic [CW-1:0] cnt;
    } flt_t;

    flt_t f_d, f_q;

    always_comb begin
        f_d    = f_q;
        f_d.s1 = raw_i;
        f_d.s2 = f_q.s1;
        if (f_q.s2 == f_q.filt) begin
            f_d.cnt = '0;
        end else if (f_q.cnt == LAST) begin
            f_d.filt = f_q.s2;
            f_d.cnt  = '0;
        end else begin
            f_d.cnt = f_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign ok_o = f_q.filt;

    // R2: the filtered level only ever moves to the value the synchroniser held
    p_filt_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.filt != $past(f_q.filt)) |-> ($past(f_q.s2) == f_q.filt));
endmodule

// File: rtl/pms_counter.sv
// Saturating up-counter with a terminal flag, cleared synchronously.
module pms_counter #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic en_i,
    output logic last_o
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)                    cnt_d = '0;
        else if (en_i && cnt_q != TOP) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last_o = en_i && (cnt_q == TOP);

    // R3: the window counter never runs past its terminal value
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TOP);
endmodule

// File: rtl/pms_gain_hold.sv
// Holds both channel gain codes; clear wins over a host write.
module pms_gain_hold #(
    parameter int GW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          accept_i,
    input  logic          wr_i,
    input  logic [GW-1:0] left_i,
    input  logic [GW-1:0] right_i,
    output logic [GW-1:0] left_o,
    output logic [GW-1:0] right_o
);
    typedef struct packed {
        logic [GW-1:0] lft;
        logic [GW-1:0] rgt;
    } gain_t;

    gain_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (clear_i) begin
            g_d = '0;
        end else if (accept_i && wr_i) begin
            g_d.lft = left_i;
            g_d.rgt = right_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign left_o  = g_q.lft;
    assign right_o = g_q.rgt;

    // R8: outside the run state a write leaves the codes where they were
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept_i && !clear_i) |=> ($stable(left_o) && $stable(right_o)));
    // R7: a preset or reset cycle leaves both codes at the mute value
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (left_o == '0 && right_o == '0));
endmodule

// File: rtl/pwr_mute_seq.sv
module pwr_mute_seq
    import pms_pkg::*;
#(
    parameter int CLK_HZ     = 12_288_000,
    parameter int RESET_MS   = 100,
    parameter int DEB_CYCLES = 8,
    parameter int CAL_LIMIT  = 65536,
    parameter int GW         = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          supply_good_i,
    input  logic          cal_done_i,
    input  logic          mute_pin_i,
    input  logic          wr_en_i,
    input  logic [GW-1:0] wr_left_i,
    input  logic [GW-1:0] wr_right_i,
    output logic          int_rst_o,
    output logic          hw_mute_o,
    output logic          cal_start_o,
    output logic          preset_o,
    output logic [GW-1:0] gain_left_o,
    output logic [GW-1:0] gain_right_o
);
    localparam int RST_CYCLES = CLK_HZ / 1000 * RESET_MS;

    typedef struct packed {
        pms_state_e st;
        logic       m1;
        logic       m2;
        logic       mprev;
        logic       cal_go;
    } seq_t;

    seq_t r_d, r_q;
    logic sup_ok;
    logic rst_last, cal_last;
    logic in_reset, in_cal, mute_rise;

    pms_supply_filter #(.DEB_CYCLES(DEB_CYCLES)) i_filter (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i (supply_good_i),
        .ok_o  (sup_ok)
    );

    assign in_reset  = (r_q.st == ST_RESET);
    assign in_cal    = (r_q.st == ST_CAL);
    assign mute_rise = r_q.m2 && !r_q.mprev;

    pms_counter #(.LIMIT(RST_CYCLES)) i_rst_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (!(in_reset && sup_ok)),
        .en_i   (in_reset && sup_ok),
        .last_o (rst_last)
    );

    pms_counter #(.LIMIT(CAL_LIMIT)) i_cal_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (!in_cal),
        .en_i   (in_cal),
        .last_o (cal_last)
    );

    always_comb begin
        r_d        = r_q;
        r_d.m1     = mute_pin_i;
        r_d.m2     = r_q.m1;
        r_d.mprev  = r_q.m2;
        r_d.cal_go = 1'b0;
        if (!sup_ok) begin
            r_d.st = ST_RESET;
        end else begin
            unique case (r_q.st)
                ST_RESET: begin
                    if (rst_last) begin
                        r_d.st     = ST_CAL;
                        r_d.cal_go = 1'b1;
                    end
                end
                ST_CAL: begin
                    if (cal_done_i || cal_last) r_d.st = ST_PRESET;
                end
                ST_PRESET: r_d.st = ST_RUN;
                ST_RUN:    r_d.cal_go = mute_rise;
                default:   r_d.st = ST_RESET;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    pms_gain_hold #(.GW(GW)) i_gains (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (in_reset || (r_q.st == ST_PRESET)),
        .accept_i (r_q.st == ST_RUN),
        .wr_i     (wr_en_i),
        .left_i   (wr_left_i),
        .right_i  (wr_right_i),
        .left_o   (gain_left_o),
        .right_o  (gain_right_o)
    );

    assign int_rst_o   = in_reset;
    assign hw_mute_o   = (r_q.st != ST_RUN) || r_q.m2;
    assign cal_start_o = r_q.cal_go;
    assign preset_o    = (r_q.st == ST_PRESET);

    // R7: a preset is only ever reached from calibration
    p_preset_from_cal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_PRESET) |-> ($past(r_q.st) == ST_CAL));
    // R9: losing the filtered supply lands in reset on the next edge
    p_loss_to_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_ok |=> (r_q.st == ST_RESET));
    // R4: calibration request is a single-cycle pulse
    p_cal_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start_o |=> !cal_start_o);
    // R4: leaving reset always comes with the calibration request
    p_cal_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_cal && $past(r_q.st) == ST_RESET) |-> cal_start_o);
    // R11: the run state is the only one allowed to release the mute
    p_mute_outside_run_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_mute_o |-> ($past(r_q.st) == ST_PRESET || $past(r_q.st) == ST_RUN));
endmodule

// File: tb/test_pwr_mute_seq.sv
module test_pwr_mute_seq;
    localparam int CLK_HZ = 1000;
    localparam int RST_MS = 100;
    localparam int DEB    = 4;
    localparam int CALL   = 20;
    localparam int RSTC   = CLK_HZ / 1000 * RST_MS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply = 1'b0, cal_done = 1'b0, mute = 1'b0, wr_en = 1'b0;
    logic [7:0] wl = '0, wr = '0;
    logic int_rst, hw_mute, cal_start, preset;
    logic [7:0] gl, gr;
    int tests = 0, failed = 0, cycles = 0;

    always #2.5 clk = ~clk;

    pwr_mute_seq #(.CLK_HZ(CLK_HZ), .RESET_MS(RST_MS), .DEB_CYCLES(DEB),
                   .CAL_LIMIT(CALL), .GW(8)) i_pwr_mute_seq (
        .clk(clk), .rst_n(rst_n), .supply_good_i(supply), .cal_done_i(cal_done),
        .mute_pin_i(mute), .wr_en_i(wr_en), .wr_left_i(wl), .wr_right_i(wr),
        .int_rst_o(int_rst), .hw_mute_o(hw_mute), .cal_start_o(cal_start),
        .preset_o(preset), .gain_left_o(gl), .gain_right_o(gr));

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            failed++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    function automatic logic sig(input int sel);
        case (sel)
            0:       return int_rst;
            1:       return preset;
            default: return hw_mute;
        endcase
    endfunction

    task automatic wait_for(input int sel, input logic val, output int n);
        n = 0;
        do begin
            step(1);
            n++;
        end while (sig(sel) != val && n < 5000);
    endtask

    task automatic bring_up(input string tag);
        int n;
        supply = 1'b1;
        wait_for(0, 1'b0, n);
        chk({tag, " reset length"}, n, RSTC + DEB + 2);
        chk({tag, " R4 cal_start pulse"}, cal_start, 1);
    endtask

    initial begin
        while (1) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                failed++;
                $display("FAIL watchdog expired");
                $display("[TB] %0d tests run, %0d failed", tests, failed);
                $finish;
            end
        end
    end

    initial begin
        int n;
        @(negedge clk);
        step(3);
        // R1 reset state
        chk("R1 int_rst", int_rst, 1);
        chk("R1 hw_mute", hw_mute, 1);
        chk("R1 cal_start", cal_start, 0);
        chk("R1 preset", preset, 0);
        chk("R1 gains", {gl, gr}, 0);
        rst_n = 1'b1;
        step(5);
        // R8 write during reset ignored
        wr_en = 1'b1; wl = 8'h55; wr = 8'h66;
        step(1);
        wr_en = 1'b0;
        step(1);
        chk("R8 write in reset ignored", {gl, gr}, 0);
        // R2 glitch sweep shorter than the debounce
        for (int len = 1; len < DEB; len++) begin
            supply = 1'b1;
            step(len);
            supply = 1'b0;
            step(RSTC + DEB + 10);
            chk($sformatf("R2 glitch len %0d", len), int_rst, 1);
        end
        // R3 R4 R6 timeout path
        bring_up("R3");
        step(1);
        chk("R4 cal_start one cycle", cal_start, 0);
        chk("R11 muted in calibrate", hw_mute, 1);
        wait_for(1, 1'b1, n);
        chk("R6 timeout length", n + 1, CALL);
        // write in the preset cycle must lose
        wr_en = 1'b1; wl = 8'hAB; wr = 8'hCD;
        step(1);
        wr_en = 1'b0;
        chk("R7 preset one cycle", preset, 0);
        chk("R8 write in preset ignored", {gl, gr}, 0);
        chk("R11 unmuted in run", hw_mute, 0);
        // R8 write sweep in run
        for (int i = 0; i < 8; i++) begin
            wr_en = 1'b1; wl = 8'(i * 37 + 1); wr = 8'(255 - i * 29);
            step(1);
            wr_en = 1'b0;
            chk($sformatf("R8 write %0d", i), {gl, gr}, {8'(i * 37 + 1), 8'(255 - i * 29)});
            wl = ~wl; wr = ~wr;
            step(1);
            chk($sformatf("R8 idle hold %0d", i), {gl, gr}, {8'(i * 37 + 1), 8'(255 - i * 29)});
        end
        // R10 mute pin in run
        mute = 1'b1;
        step(1);
        chk("R10 mute latency 1", hw_mute, 0);
        step(1);
        chk("R10 mute set", hw_mute, 1);
        chk("R10 no early cal", cal_start, 0);
        step(1);
        chk("R10 cal pulse", cal_start, 1);
        step(1);
        chk("R10 cal pulse end", cal_start, 0);
        chk("R10 gains kept", {gl, gr}, {8'(7 * 37 + 1), 8'(255 - 7 * 29)});
        chk("R10 no reset", int_rst, 0);
        mute = 1'b0;
        step(2);
        chk("R10 mute release", hw_mute, 0);
        // R2 short dip in run is ignored
        supply = 1'b0;
        step(DEB - 1);
        supply = 1'b1;
        step(DEB + 6);
        chk("R2 short dip int_rst", int_rst, 0);
        chk("R2 short dip hw_mute", hw_mute, 0);
        // R9 supply loss from run
        supply = 1'b0;
        wait_for(0, 1'b1, n);
        chk("R9 loss latency", n, DEB + 3);
        step(2);
        chk("R9 gains cleared", {gl, gr}, 0);
        chk("R9 hw_mute", hw_mute, 1);
        step(DEB + 5);
        // R5 early calibration done, rerun of the sequence
        bring_up("R9 rerun");
        cal_done = 1'b1;
        step(1);
        cal_done = 1'b0;
        chk("R5 preset after done", preset, 1);
        step(1);
        chk("R5 preset single", preset, 0);
        chk("R5 run gains", {gl, gr}, 0);
        // R6 done on the final timeout cycle
        supply = 1'b0;
        step(DEB + 10);
        bring_up("R6 coincide");
        step(CALL - 1);
        chk("R6 no early preset", preset, 0);
        cal_done = 1'b1;
        step(1);
        cal_done = 1'b0;
        chk("R6 coincide preset", preset, 1);
        step(1);
        chk("R6 coincide single", preset, 0);
        chk("R6 coincide run", hw_mute, 0);
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end
endmodule